// File: doc/BRIEF.md
# Exception Vector and Syndrome Unit

This block sits next to a simple processor pipeline. It gathers every exception request the core can see, picks the single most urgent one each clock, and hands the fetch stage a 32-bit vector address to jump to. Requests fall into two classes. The first is resets and machine checks, which no enable can hold off. The second is the system-management interrupt, the external interrupt and the decrementer, which count only while the core's interrupt-enable input is high.

A vector is a 20-bit cause offset placed on one of two bases. The base is chosen by a prefix bit. That bit is captured from the hard-reset configuration word on the block's own reset and again whenever the hard-reset request is asserted. When a data-access fault is the cause taken, the block also loads a 32-bit fault status word. The word holds one flag per fault reason and the direction of the access. The pipeline supplies address translation and protection results as input flags; saving state and returning from the handler happen elsewhere.

Top module: `exc_vector_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `exc_taken`=0, `exc_vec`=0, `exc_nonmask`=0 and `dacc_status`=0. The prefix bit is loaded from `cfg_word[PFX_POS]`.
- R2: A soft or hard reset request is taken with offset 0x00100 whatever the other inputs are. It sets `exc_nonmask` to 1 and ignores `int_en`.
- R3: A machine check is taken with offset 0x00200 when any of these is high: `mcp_pin`, `apar_err`, `dpar_err`, or `tea_err` while `dbus_busy` is high. `tea_err` with `dbus_busy` low has no effect. The class is nonmaskable (`exc_nonmask`=1).
- R4: A data-access fault (`dacc_fault`) is taken with offset 0x00300 and loads `dacc_status`.
- R5: Three sources are taken only while `int_en` is 1: the system-management interrupt (offset 0x01400), the external interrupt (offset 0x00500) and the decrementer (offset 0x00900). They report `exc_nonmask`=0. With `int_en`=0 they raise nothing.
- R6: When several requests are present in one cycle, only the highest one is taken. The order from highest to lowest is reset, machine check, data-access fault, system-management interrupt, external interrupt, decrementer.
- R7: `exc_vec` is 0xFFF00000 plus the offset when the prefix bit is 1, and the offset alone when it is 0. In a cycle where `hrst_req` is high, the vector already uses the new `cfg_word[PFX_POS]`. `srst_req` never reloads the prefix.
- R8: `dacc_status` uses MSB-first numbering, so fault bit n sits at vector position DSR_W-1-n. The fault bits are:
  - Bit 1 is `xlat_miss`.
  - Bit 4 is `prot_deny`.
  - Bit 5 is set by an `ectl_access` to a `wt_target`, or by `dstore_seg`.
  - Bit 6 is `is_store` (1 store, 0 load).
  - Bit 11 is `ectl_access` with `ectl_disabled`.

  Every other bit reads 0.
- R9: `dacc_status` changes only when a data-access fault is the cause taken. A fault that loses to a reset or machine check leaves it unchanged.
- R10: `exc_taken` is high for exactly the cycle after each edge at which an eligible request is present, and low otherwise. `exc_vec` holds its last value while no exception is taken. The offset field (bits 19:0) is never zero while `exc_taken` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| cfg_word | input | CFG_W | Hard-reset configuration word; bit PFX_POS is the vector prefix |
| srst_req | input | 1 | Soft reset request |
| hrst_req | input | 1 | Hard reset request; also reloads the prefix |
| mcp_pin | input | 1 | Machine-check pin |
| tea_err | input | 1 | Transfer error acknowledge |
| dbus_busy | input | 1 | A data bus transaction is in progress |
| apar_err | input | 1 | Address parity error |
| dpar_err | input | 1 | Data parity error |
| dacc_fault | input | 1 | Data-access fault request |
| xlat_miss | input | 1 | Translation found no match |
| prot_deny | input | 1 | Protection check forbids the access |
| ectl_access | input | 1 | Faulting access is an external-control read or write |
| wt_target | input | 1 | Target address is write-through |
| dstore_seg | input | 1 | Load/store reached a direct-store segment |
| ectl_disabled | input | 1 | External-control enable bit is clear |
| is_store | input | 1 | Faulting access is a store |
| smi_req | input | 1 | System-management interrupt request |
| ext_irq | input | 1 | External interrupt request |
| dec_req | input | 1 | Decrementer request |
| int_en | input | 1 | Interrupt enable for the maskable class |
| exc_taken | output | 1 | One-cycle strobe: an exception is taken |
| exc_vec | output | VEC_W | Vector address of the taken exception |
| exc_nonmask | output | 1 | Taken exception belongs to the nonmaskable class |
| dacc_status | output | DSR_W | Captured data-access fault status |

## Verification
The bench builds the block with `CFG_W`=16 and `PFX_POS`=11, so the prefix sits in a narrow configuration word rather than at the default position. This shows that only the chosen bit steers the base. It also allows directed cases where other configuration bits toggle without effect. `DSR_W` and `VEC_W` stay at 32, so every expected status word and vector is a literal 32-bit constant that the directed checks can state exactly. Random cycles with sparse requests and a toggling `int_en` then reach the priority collisions and the masked-quiet case against a bench model.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

  localparam int NUM_CAUSE = 6;
  localparam int OFS_W     = 20;
  localparam int NUM_DFLAG = 5;

  // Cause codes double as priority rank: lower value wins.
  typedef enum logic [2:0] {
    CZ_RESET = 3'd0,
    CZ_MCHK  = 3'd1,
    CZ_DACC  = 3'd2,
    CZ_SMI   = 3'd3,
    CZ_EXT   = 3'd4,
    CZ_DEC   = 3'd5,
    CZ_NONE  = 3'd7
  } cause_e;

  // MSB-first fault bit numbers, in the flag order used by exc_dsr_fmt.
  localparam int unsigned DFLAG_NUM [NUM_DFLAG] = '{1, 4, 5, 6, 11};

  function automatic logic [OFS_W-1:0] cause_offset(cause_e c);
    case (c)
      CZ_RESET: cause_offset = 20'h00100;
      CZ_MCHK:  cause_offset = 20'h00200;
      CZ_DACC:  cause_offset = 20'h00300;
      CZ_SMI:   cause_offset = 20'h01400;
      CZ_EXT:   cause_offset = 20'h00500;
      CZ_DEC:   cause_offset = 20'h00900;
      default:  cause_offset = 20'h00100;
    endcase
  endfunction

endpackage

// File: rtl/exc_src_collect.sv
module exc_src_collect
  import exc_vec_pkg::*;
(
  input  logic                 srst_req,
  input  logic                 hrst_req,
  input  logic                 mcp_pin,
  input  logic                 tea_err,
  input  logic                 dbus_busy,
  input  logic                 apar_err,
  input  logic                 dpar_err,
  input  logic                 dacc_fault,
  input  logic                 smi_req,
  input  logic                 ext_irq,
  input  logic                 dec_req,
  input  logic                 int_en,
  output logic [NUM_CAUSE-1:0] req
);

  logic bus_err;
  assign bus_err = tea_err & dbus_busy;

  always_comb begin
    req           = '0;
    req[CZ_RESET] = srst_req | hrst_req;
    req[CZ_MCHK]  = bus_err | mcp_pin | apar_err | dpar_err;
    req[CZ_DACC]  = dacc_fault;
    req[CZ_SMI]   = smi_req & int_en;
    req[CZ_EXT]   = ext_irq & int_en;
    req[CZ_DEC]   = dec_req & int_en;
  end

endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int N  = 6,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);

  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]     = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end

  assign any = blocked[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/exc_dsr_fmt.sv
module exc_dsr_fmt
  import exc_vec_pkg::*;
#(
  parameter int DSR_W = 32
) (
  input  logic                 xlat_miss,
  input  logic                 prot_deny,
  input  logic                 ectl_access,
  input  logic                 wt_target,
  input  logic                 dstore_seg,
  input  logic                 ectl_disabled,
  input  logic                 is_store,
  output logic [DSR_W-1:0]     word
);

  logic [NUM_DFLAG-1:0] flag;

  assign flag[0] = xlat_miss;
  assign flag[1] = prot_deny;
  assign flag[2] = (ectl_access & wt_target) | dstore_seg;
  assign flag[3] = is_store;
  assign flag[4] = ectl_access & ectl_disabled;

  always_comb begin
    word = '0;
    for (int k = 0; k < NUM_DFLAG; k++) begin
      word[DSR_W-1-DFLAG_NUM[k]] = flag[k];
    end
  end

endmodule

// File: rtl/exc_vec_form.sv
module exc_vec_form
  import exc_vec_pkg::*;
#(
  parameter int               VEC_W     = 32,
  parameter logic [VEC_W-1:0] HIGH_BASE = 32'hFFF0_0000
) (
  input  logic             pfx,
  input  cause_e           cause,
  output logic [VEC_W-1:0] vec
);

  logic [VEC_W-1:0] base;
  assign base = pfx ? HIGH_BASE : '0;
  assign vec  = base | VEC_W'(cause_offset(cause));

endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_vec_pkg::*;
#(
  parameter int               CFG_W     = 32,
  parameter int               PFX_POS   = 7,
  parameter int               VEC_W     = 32,
  parameter int               DSR_W     = 32,
  parameter logic [VEC_W-1:0] HIGH_BASE = 32'hFFF0_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             srst_req,
  input  logic             hrst_req,
  input  logic             mcp_pin,
  input  logic             tea_err,
  input  logic             dbus_busy,
  input  logic             apar_err,
  input  logic             dpar_err,
  input  logic             dacc_fault,
  input  logic             xlat_miss,
  input  logic             prot_deny,
  input  logic             ectl_access,
  input  logic             wt_target,
  input  logic             dstore_seg,
  input  logic             ectl_disabled,
  input  logic             is_store,
  input  logic             smi_req,
  input  logic             ext_irq,
  input  logic             dec_req,
  input  logic             int_en,
  output logic             exc_taken,
  output logic [VEC_W-1:0] exc_vec,
  output logic             exc_nonmask,
  output logic [DSR_W-1:0] dacc_status
);

  localparam int IDX_W = $clog2(NUM_CAUSE);

  logic [NUM_CAUSE-1:0] req;
  logic [NUM_CAUSE-1:0] grant;
  logic [IDX_W-1:0]     win_idx;
  logic                 win_any;
  cause_e               win_cause;
  logic                 pfx_q;
  logic                 pfx_eff;
  logic [VEC_W-1:0]     vec_n;
  logic [DSR_W-1:0]     dsr_n;

  exc_src_collect u_src (
    .srst_req  (srst_req),
    .hrst_req  (hrst_req),
    .mcp_pin   (mcp_pin),
    .tea_err   (tea_err),
    .dbus_busy (dbus_busy),
    .apar_err  (apar_err),
    .dpar_err  (dpar_err),
    .dacc_fault(dacc_fault),
    .smi_req   (smi_req),
    .ext_irq   (ext_irq),
    .dec_req   (dec_req),
    .int_en    (int_en),
    .req       (req)
  );

  exc_prio_pick #(.N(NUM_CAUSE), .IW(IDX_W)) u_pick (
    .req  (req),
    .grant(grant),
    .idx  (win_idx),
    .any  (win_any)
  );

  assign win_cause = win_any ? cause_e'(win_idx) : CZ_NONE;

  // A hard reset request carries a fresh configuration word; use it at once.
  assign pfx_eff = hrst_req ? cfg_word[PFX_POS] : pfx_q;

  exc_vec_form #(.VEC_W(VEC_W), .HIGH_BASE(HIGH_BASE)) u_form (
    .pfx  (pfx_eff),
    .cause(win_cause),
    .vec  (vec_n)
  );

  exc_dsr_fmt #(.DSR_W(DSR_W)) u_dsr (
    .xlat_miss    (xlat_miss),
    .prot_deny    (prot_deny),
    .ectl_access  (ectl_access),
    .wt_target    (wt_target),
    .dstore_seg   (dstore_seg),
    .ectl_disabled(ectl_disabled),
    .is_store     (is_store),
    .word         (dsr_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_taken   <= 1'b0;
      exc_vec     <= '0;
      exc_nonmask <= 1'b0;
      dacc_status <= '0;
      pfx_q       <= cfg_word[PFX_POS];
    end else begin
      exc_taken <= win_any;
      if (win_any) begin
        exc_vec     <= vec_n;
        exc_nonmask <= grant[CZ_RESET] | grant[CZ_MCHK];
      end
      if (grant[CZ_DACC]) dacc_status <= dsr_n;
      if (hrst_req)       pfx_q       <= cfg_word[PFX_POS];
    end
  end

endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk
  import exc_vec_pkg::*;
#(
  parameter int VEC_W = 32,
  parameter int DSR_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             srst_req,
  input logic             hrst_req,
  input logic             mcp_pin,
  input logic             tea_err,
  input logic             dbus_busy,
  input logic             apar_err,
  input logic             dpar_err,
  input logic             dacc_fault,
  input logic             int_en,
  input logic             exc_taken,
  input logic [VEC_W-1:0] exc_vec,
  input logic             exc_nonmask,
  input logic [DSR_W-1:0] dacc_status
);

  function automatic logic [DSR_W-1:0] legal_bits();
    logic [DSR_W-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_DFLAG; k++) m[DSR_W-1-DFLAG_NUM[k]] = 1'b1;
    return m;
  endfunction

  localparam logic [DSR_W-1:0] DSR_LEGAL = legal_bits();

  logic [OFS_W-1:0] ofs;
  logic             mchk_any;
  assign ofs      = exc_vec[OFS_W-1:0];
  assign mchk_any = mcp_pin | apar_err | dpar_err | (tea_err & dbus_busy);

  AST_VEC_NONZERO: assert property (@(posedge clk) disable iff (rst)
    exc_taken |-> (ofs != '0)); // R10

  AST_RESET_FIRST: assert property (@(posedge clk) disable iff (rst)
    (srst_req | hrst_req) |=> (exc_taken && ofs == 20'h00100 && exc_nonmask)); // R2

  AST_MCHK_OVER_FAULT: assert property (@(posedge clk) disable iff (rst)
    (!srst_req && !hrst_req && mchk_any) |=> (exc_taken && ofs == 20'h00200)); // R6

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!int_en && !srst_req && !hrst_req && !mchk_any && !dacc_fault) |=> !exc_taken); // R5

  AST_DSR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !dacc_fault |=> $stable(dacc_status)); // R9

  AST_DSR_LAYOUT: assert property (@(posedge clk) disable iff (rst)
    (dacc_status & ~DSR_LEGAL) == '0); // R8

  AST_CLASS_MATCH: assert property (@(posedge clk) disable iff (rst)
    exc_taken |-> (exc_nonmask == (ofs == 20'h00100 || ofs == 20'h00200))); // R5

endmodule

bind exc_vector_unit exc_vector_unit_chk #(.VEC_W(VEC_W), .DSR_W(DSR_W)) u_chk (.*);

// File: tb/exc_vector_unit_bench.sv
`timescale 1ns/1ps
module exc_vector_unit_bench;

  localparam int CFG_W   = 16;
  localparam int PFX_POS = 11;
  localparam int VEC_W   = 32;
  localparam int DSR_W   = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CFG_W-1:0] cfg_word = '0;
  logic srst_req = 0, hrst_req = 0, mcp_pin = 0, tea_err = 0, dbus_busy = 0;
  logic apar_err = 0, dpar_err = 0, dacc_fault = 0, xlat_miss = 0, prot_deny = 0;
  logic ectl_access = 0, wt_target = 0, dstore_seg = 0, ectl_disabled = 0, is_store = 0;
  logic smi_req = 0, ext_irq = 0, dec_req = 0, int_en = 0;
  logic             exc_taken;
  logic [VEC_W-1:0] exc_vec;
  logic             exc_nonmask;
  logic [DSR_W-1:0] dacc_status;

  always #2 clk = ~clk;

  exc_vector_unit #(.CFG_W(CFG_W), .PFX_POS(PFX_POS), .VEC_W(VEC_W), .DSR_W(DSR_W)) u_exc_vector_unit (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .srst_req(srst_req), .hrst_req(hrst_req),
    .mcp_pin(mcp_pin), .tea_err(tea_err), .dbus_busy(dbus_busy), .apar_err(apar_err),
    .dpar_err(dpar_err), .dacc_fault(dacc_fault), .xlat_miss(xlat_miss), .prot_deny(prot_deny),
    .ectl_access(ectl_access), .wt_target(wt_target), .dstore_seg(dstore_seg),
    .ectl_disabled(ectl_disabled), .is_store(is_store), .smi_req(smi_req), .ext_irq(ext_irq),
    .dec_req(dec_req), .int_en(int_en), .exc_taken(exc_taken), .exc_vec(exc_vec),
    .exc_nonmask(exc_nonmask), .dacc_status(dacc_status)
  );

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  logic        m_taken, m_nm, m_pfx;
  logic [31:0] m_vec, m_dsr;
  int          m_cause;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Cause rank: 0 reset, 1 machine check, 2 data fault, 3 smi, 4 ext, 5 dec, 7 none (R6).
  function automatic int pick_cause();
    if (srst_req || hrst_req) return 0;
    if (mcp_pin || apar_err || dpar_err || (tea_err && dbus_busy)) return 1;
    if (dacc_fault) return 2;
    if (int_en && smi_req) return 3;
    if (int_en && ext_irq) return 4;
    if (int_en && dec_req) return 5;
    return 7;
  endfunction

  function automatic logic [31:0] offset_of(int c);
    case (c)
      0: return 32'h00100;
      1: return 32'h00200;
      2: return 32'h00300;
      3: return 32'h01400;
      4: return 32'h00500;
      5: return 32'h00900;
      default: return 32'h0;
    endcase
  endfunction

  // MSB-first: bit n lives at position 31-n (R8).
  function automatic logic [31:0] status_of();
    logic [31:0] w;
    w = '0;
    w[30] = xlat_miss;
    w[27] = prot_deny;
    w[26] = (ectl_access && wt_target) || dstore_seg;
    w[25] = is_store;
    w[20] = ectl_access && ectl_disabled;
    return w;
  endfunction

  function automatic string tag_of(int c);
    case (c)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4, 5: return "R5";
      default: return "R10";
    endcase
  endfunction

  function automatic void model_step();
    logic pe;
    if (rst) begin
      m_taken = 0; m_vec = 0; m_nm = 0; m_dsr = 0; m_pfx = cfg_word[PFX_POS]; m_cause = 7;
      return;
    end
    pe = hrst_req ? cfg_word[PFX_POS] : m_pfx;
    m_cause = pick_cause();
    m_taken = (m_cause != 7);
    if (m_taken) begin
      m_vec = (pe ? 32'hFFF0_0000 : 32'h0) | offset_of(m_cause);
      m_nm  = (m_cause < 2);
    end
    if (m_cause == 2) m_dsr = status_of();
    if (hrst_req) m_pfx = cfg_word[PFX_POS];
  endfunction

  task automatic tick(input string tag);
    string t;
    model_step();
    @(posedge clk);
    @(negedge clk);
    t = (tag == "") ? tag_of(m_cause) : tag;
    check({t, " taken"},   {31'b0, exc_taken},   {31'b0, m_taken});
    check({t, " vector"},  exc_vec,              m_vec);
    check({t, " class"},   {31'b0, exc_nonmask}, {31'b0, m_nm});
    check({t, " status"},  dacc_status,          m_dsr);
  endtask

  task automatic clear_in();
    srst_req = 0; hrst_req = 0; mcp_pin = 0; tea_err = 0; dbus_busy = 0;
    apar_err = 0; dpar_err = 0; dacc_fault = 0; xlat_miss = 0; prot_deny = 0;
    ectl_access = 0; wt_target = 0; dstore_seg = 0; ectl_disabled = 0; is_store = 0;
    smi_req = 0; ext_irq = 0; dec_req = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset with prefix bit at 0, other config bits set
    cfg_word = 16'h07FF;
    rst = 1;
    tick("R1"); tick("R1");
    check("R1 taken after reset", {31'b0, exc_taken}, 32'h0);
    check("R1 vector after reset", exc_vec, 32'h0);
    check("R1 status after reset", dacc_status, 32'h0);
    rst = 0;
    tick("R10");

    // R2, R7: soft reset on low base, int_en ignored
    int_en = 0; srst_req = 1; ext_irq = 1;
    tick("R2");
    check("R2 soft reset vector", exc_vec, 32'h0000_0100);
    clear_in();
    tick("R10");
    check("R10 strobe drops", {31'b0, exc_taken}, 32'h0);
    check("R10 vector held", exc_vec, 32'h0000_0100);

    // R7: hard reset loads prefix 1 and uses it in the same cycle
    cfg_word = 16'h0800; hrst_req = 1;
    tick("R7");
    check("R7 hard reset high base", exc_vec, 32'hFFF0_0100);
    clear_in(); cfg_word = 16'h0000;
    srst_req = 1;
    tick("R7");
    check("R7 soft reset keeps prefix", exc_vec, 32'hFFF0_0100);
    clear_in();

    // R3: bus error outside a transaction is ignored
    tea_err = 1; dbus_busy = 0;
    tick("R3");
    check("R3 idle bus error ignored", {31'b0, exc_taken}, 32'h0);
    dbus_busy = 1;
    tick("R3");
    check("R3 bus error in transaction", exc_vec, 32'hFFF0_0200);
    clear_in();

    // R4, R8: miss + store + disabled external control
    dacc_fault = 1; xlat_miss = 1; is_store = 1; ectl_access = 1; ectl_disabled = 1;
    tick("R4");
    check("R4 data fault vector", exc_vec, 32'hFFF0_0300);
    check("R8 status miss/store/disabled", dacc_status, 32'h4210_0000);
    clear_in();
    dacc_fault = 1; dstore_seg = 1;
    tick("R8");
    check("R8 status direct-store load", dacc_status, 32'h0400_0000);
    clear_in();
    dacc_fault = 1; prot_deny = 1; ectl_access = 1; wt_target = 1;
    tick("R8");
    check("R8 status protection+write-through", dacc_status, 32'h0C00_0000);
    clear_in();

    // R9: fault losing to a machine check leaves status untouched
    dacc_fault = 1; xlat_miss = 1; apar_err = 1;
    tick("R9");
    check("R9 status held", dacc_status, 32'h0C00_0000);
    check("R9 winner is machine check", exc_vec, 32'hFFF0_0200);
    clear_in();

    // R5, R6: maskable ordering and masking
    smi_req = 1; ext_irq = 1; dec_req = 1; int_en = 0;
    tick("R5");
    check("R5 masked sources quiet", {31'b0, exc_taken}, 32'h0);
    int_en = 1;
    tick("R6");
    check("R6 smi wins", exc_vec, 32'hFFF0_1400);
    check("R5 maskable class", {31'b0, exc_nonmask}, 32'h0);
    smi_req = 0;
    tick("R6");
    check("R6 ext over dec", exc_vec, 32'hFFF0_0500);
    ext_irq = 0;
    tick("R5");
    check("R5 decrementer", exc_vec, 32'hFFF0_0900);
    clear_in();

    // Random phase with sparse requests
    for (int n = 0; n < 600; n++) begin
      srst_req   = ($urandom_range(0, 39) == 0);
      hrst_req   = ($urandom_range(0, 59) == 0);
      cfg_word   = CFG_W'($urandom);
      mcp_pin    = ($urandom_range(0, 19) == 0);
      tea_err    = ($urandom_range(0, 7) == 0);
      dbus_busy  = $urandom_range(0, 1);
      apar_err   = ($urandom_range(0, 29) == 0);
      dpar_err   = ($urandom_range(0, 29) == 0);
      dacc_fault = ($urandom_range(0, 4) == 0);
      xlat_miss  = $urandom_range(0, 1);
      prot_deny  = $urandom_range(0, 1);
      ectl_access = $urandom_range(0, 1);
      wt_target  = $urandom_range(0, 1);
      dstore_seg = $urandom_range(0, 1);
      ectl_disabled = $urandom_range(0, 1);
      is_store   = $urandom_range(0, 1);
      smi_req    = ($urandom_range(0, 5) == 0);
      ext_irq    = ($urandom_range(0, 3) == 0);
      dec_req    = ($urandom_range(0, 3) == 0);
      int_en     = $urandom_range(0, 1);
      tick("");
    end
    clear_in();
    tick("R10");

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule